// File: doc/BRIEF.md
# GPIO Loopback Self-Test Engine

This block is a built-in self-test sequencer that sits between a bank of general-purpose I/O control registers and the pad ring. While idle it passes the functional direction and output-value controls straight to the pads. A start pulse makes it take over every pin. It first drives all tested pins to one level and then to the other, and compares what comes back on the input path. It then walks each pair of adjacent pins, driving one high and its neighbour low in both orders. The pads resolve a contention to the low level, so if both pins of such a pair read low, the pair is shorted.

Two loopback variants are selectable at start. In pad mode the engine drives the pad buffers and reads the pad input path, so the pin itself is exercised. In digital mode the pins are not touched at all and the read-back is taken from the engine's own drive values, which tests only the internal logic. No external wiring between pins is needed in either mode. A per-pin exclude mask protects pins that must not toggle. Before the test the engine snapshots the functional controls, and it drives that snapshot again in its final cycle. The test can be run after power-up and again at any later idle time.

Top module: `gpio_lbist`

## Requirements
- R1: After reset busy, done, fail, pin_fault and pair_short are all 0, and while idle pad_dir and pad_out equal func_dir and func_out.
- R2: A start pulse is accepted only while busy is 0. It raises busy on the next cycle. A start pulse seen while busy is 1 has no effect on the run or its results. done is 1 from the end of a run until the next accepted start.
- R3: A run has 2 + 2*(N_PINS-1) test phases, each lasting settle_cycles+1 cycles, followed by one restore cycle. busy is therefore 1 for (2+2*(N_PINS-1))*(settle_cycles+1)+1 cycles.
- R4: In pad mode (mode = 1), pin_fault[i] is set when pin i does not read 1 while driven high or does not read 0 while driven low.
- R5: In pad mode, pair_short[p] covers pins p and p+1. It is set when both pins read 0 while one of them is driven high and the other low, in either order.
- R6: pair_short[p] is never set when pin p or pin p+1 is excluded or has its pin_fault bit set.
- R7: An excluded pin (exclude mask bit 1) keeps its snapshot direction and output value on the pads for the whole run, and its pin_fault bit stays 0.
- R8: In digital mode (mode = 0), every pad output keeps its snapshot value for the whole run, and no pin_fault or pair_short bit is set whatever the pads return.
- R9: In the final busy cycle the pads carry the direction and output values that func_dir and func_out had when start was accepted, even if those inputs changed during the run. From the next cycle on, the pads follow func_dir and func_out again.
- R10: fail is set at the end of a run if any pin_fault or pair_short bit is 1. fail holds, together with the result vectors, until the next accepted start, which clears fail, done and both vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request pulse |
| mode | input | 1 | 1 = loop through pad buffers, 0 = internal digital loop; latched at start |
| settle_cycles | input | SETTLE_W | Extra wait cycles before each sample; latched at start |
| excl_mask | input | N_PINS | Pins left untouched by the test; latched at start |
| func_dir | input | N_PINS | Functional direction per pin (1 = output) |
| func_out | input | N_PINS | Functional output value per pin |
| pad_dir | output | N_PINS | Direction control to the pads |
| pad_out | output | N_PINS | Output value to the pads |
| pad_in | input | N_PINS | Sampled pad input levels |
| busy | output | 1 | Test run in progress |
| done | output | 1 | Run finished; cleared by the next start |
| fail | output | 1 | Sticky: any fault or short found in the last run |
| pin_fault | output | N_PINS | Per-pin stuck-level fault |
| pair_short | output | N_PINS-1 | Per-adjacent-pair short; bit p covers pins p and p+1 |

## Verification
The bench builds the engine with N_PINS = 6 and SETTLE_W = 3. This keeps every run short enough that settle values from 0 to 7 can be swept, and it keeps the bank small enough that a stuck pin, a shorted pair and excluded pins at both edges of the bank can sit in one run without interfering. The pad model is a wired-AND net with pull-ups and injectable stuck levels and shorts. With it the scoreboard can show that a short next to a stuck pin is masked, that an excluded edge pin suppresses its pair, and that digital mode hides every injected pad fault.

// File: rtl/gpio_lbist_pkg.sv
package gpio_lbist_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_STK_HI  = 3'd1,
        PH_STK_LO  = 3'd2,
        PH_PAIR_A  = 3'd3,
        PH_PAIR_B  = 3'd4,
        PH_RESTORE = 3'd5
    } phase_e;

    typedef struct packed {
        logic accept;   // start taken this cycle
        logic busy;     // engine owns the pads
        logic sample;   // settle window over, compare now
        logic restore;  // final cycle of a run
    } ctl_t;

    function automatic logic is_test(phase_e ph);
        return (ph == PH_STK_HI) || (ph == PH_STK_LO) ||
               (ph == PH_PAIR_A) || (ph == PH_PAIR_B);
    endfunction

    function automatic logic is_pair(phase_e ph);
        return (ph == PH_PAIR_A) || (ph == PH_PAIR_B);
    endfunction

    // level a tested pin carries; lead = lower pin of the active pair
    function automatic logic drive_level(phase_e ph, logic lead);
        case (ph)
            PH_STK_HI: return 1'b1;
            PH_PAIR_A: return lead;
            PH_PAIR_B: return ~lead;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lbist_seq.sv
module lbist_seq
    import gpio_lbist_pkg::*;
#(
    parameter int N_PINS   = 8,
    parameter int SETTLE_W = 4,
    parameter int PW       = $clog2(N_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                mode,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [N_PINS-1:0]   excl_mask,
    output phase_e              phase,
    output logic [PW-1:0]       pidx,
    output ctl_t                ctl,
    output logic                mode_q,
    output logic [N_PINS-1:0]   excl_q,
    output logic                done
);
    localparam logic [PW-1:0] LAST_PAIR = PW'(N_PINS - 2);

    logic [SETTLE_W-1:0] cnt;
    logic [SETTLE_W-1:0] settle_q;

    always_comb begin
        ctl.accept  = start && (phase == PH_IDLE);
        ctl.busy    = (phase != PH_IDLE);
        ctl.sample  = is_test(phase) && (cnt == '0);
        ctl.restore = (phase == PH_RESTORE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            settle_q <= '0;
            pidx     <= '0;
            mode_q   <= 1'b0;
            excl_q   <= '0;
            done     <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase    <= PH_STK_HI;
                        cnt      <= settle_cycles;
                        settle_q <= settle_cycles;
                        mode_q   <= mode;
                        excl_q   <= excl_mask;
                        pidx     <= '0;
                        done     <= 1'b0;
                    end
                end
                PH_RESTORE: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        cnt <= settle_q;
                        case (phase)
                            PH_STK_HI: phase <= PH_STK_LO;
                            PH_STK_LO: begin
                                phase <= PH_PAIR_A;
                                pidx  <= '0;
                            end
                            PH_PAIR_A: phase <= PH_PAIR_B;
                            PH_PAIR_B: begin
                                if (pidx == LAST_PAIR) begin
                                    phase <= PH_RESTORE;
                                end else begin
                                    pidx  <= pidx + 1'b1;
                                    phase <= PH_PAIR_A;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lbist_drive.sv
module lbist_drive
    import gpio_lbist_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int PW     = $clog2(N_PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  phase_e            phase,
    input  logic [PW-1:0]     pidx,
    input  logic              mode_q,
    input  logic [N_PINS-1:0] excl_q,
    input  logic [N_PINS-1:0] func_dir,
    input  logic [N_PINS-1:0] func_out,
    output logic [N_PINS-1:0] pad_dir,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] lvl
);
    logic [N_PINS-1:0] snap_dir;
    logic [N_PINS-1:0] snap_out;
    logic [PW-1:0]     pnext;

    assign pnext = pidx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_dir <= '0;
            snap_out <= '0;
        end else if (ctl.accept) begin
            snap_dir <= func_dir;
            snap_out <= func_out;
        end
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic lead, in_pair, tested, own, release_pin;

        assign lead        = (pidx == PW'(i));
        assign in_pair     = lead || (pnext == PW'(i));
        assign tested      = mode_q && !excl_q[i] && is_test(phase);
        assign own         = tested && (!is_pair(phase) || in_pair);
        assign release_pin = tested && is_pair(phase) && !in_pair;
        assign lvl[i]      = drive_level(phase, lead);

        always_comb begin
            if (!ctl.busy) begin
                pad_dir[i] = func_dir[i];
                pad_out[i] = func_out[i];
            end else if (own) begin
                pad_dir[i] = 1'b1;
                pad_out[i] = lvl[i];
            end else if (release_pin) begin
                pad_dir[i] = 1'b0;
                pad_out[i] = snap_out[i];
            end else begin
                pad_dir[i] = snap_dir[i];
                pad_out[i] = snap_out[i];
            end
        end
    end
endmodule

// File: rtl/lbist_judge.sv
module lbist_judge
    import gpio_lbist_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int PW     = $clog2(N_PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  phase_e            phase,
    input  logic [PW-1:0]     pidx,
    input  logic              mode_q,
    input  logic [N_PINS-1:0] excl_q,
    input  logic [N_PINS-1:0] lvl,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pin_fault,
    output logic [N_PINS-2:0] pair_short,
    output logic              fail
);
    logic [N_PINS-1:0] rd;
    logic [PW-1:0]     pnext;
    logic              both_low, pair_ok;

    // pad path or internal loop
    assign rd       = mode_q ? pad_in : lvl;
    assign pnext    = pidx + 1'b1;
    assign both_low = !rd[pidx] && !rd[pnext];
    assign pair_ok  = !excl_q[pidx] && !excl_q[pnext] &&
                      !pin_fault[pidx] && !pin_fault[pnext];

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_fault  <= '0;
            pair_short <= '0;
            fail       <= 1'b0;
        end else if (ctl.accept) begin
            pin_fault  <= '0;
            pair_short <= '0;
            fail       <= 1'b0;
        end else begin
            if (ctl.sample && !is_pair(phase)) begin
                pin_fault <= pin_fault | (~excl_q & (rd ^ lvl));
            end
            if (ctl.sample && is_pair(phase) && pair_ok && both_low) begin
                pair_short[pidx] <= 1'b1;
            end
            if (ctl.restore && ((|pin_fault) || (|pair_short))) begin
                fail <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_lbist.sv
module gpio_lbist
    import gpio_lbist_pkg::*;
#(
    parameter int N_PINS   = 8,
    parameter int SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                mode,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [N_PINS-1:0]   excl_mask,
    input  logic [N_PINS-1:0]   func_dir,
    input  logic [N_PINS-1:0]   func_out,
    output logic [N_PINS-1:0]   pad_dir,
    output logic [N_PINS-1:0]   pad_out,
    input  logic [N_PINS-1:0]   pad_in,
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic [N_PINS-1:0]   pin_fault,
    output logic [N_PINS-2:0]   pair_short
);
    localparam int PW = $clog2(N_PINS);

    phase_e            phase;
    logic [PW-1:0]     pidx;
    ctl_t              ctl;
    logic              mode_q;
    logic [N_PINS-1:0] excl_q;
    logic [N_PINS-1:0] lvl;

    assign busy = ctl.busy;

    lbist_seq #(.N_PINS(N_PINS), .SETTLE_W(SETTLE_W), .PW(PW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .settle_cycles(settle_cycles), .excl_mask(excl_mask),
        .phase(phase), .pidx(pidx), .ctl(ctl),
        .mode_q(mode_q), .excl_q(excl_q), .done(done)
    );

    lbist_drive #(.N_PINS(N_PINS), .PW(PW)) u_drive (
        .clk(clk), .rst(rst), .ctl(ctl), .phase(phase), .pidx(pidx),
        .mode_q(mode_q), .excl_q(excl_q),
        .func_dir(func_dir), .func_out(func_out),
        .pad_dir(pad_dir), .pad_out(pad_out), .lvl(lvl)
    );

    lbist_judge #(.N_PINS(N_PINS), .PW(PW)) u_judge (
        .clk(clk), .rst(rst), .ctl(ctl), .phase(phase), .pidx(pidx),
        .mode_q(mode_q), .excl_q(excl_q), .lvl(lvl), .pad_in(pad_in),
        .pin_fault(pin_fault), .pair_short(pair_short), .fail(fail)
    );
endmodule

// File: rtl/gpio_lbist_chk.sv
module gpio_lbist_chk #(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [N_PINS-1:0] pin_fault,
    input logic [N_PINS-2:0] pair_short,
    input logic [N_PINS-1:0] pad_dir,
    input logic [N_PINS-1:0] pad_out,
    input logic              mode_q,
    input logic [N_PINS-1:0] excl_q
);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10
    fail_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> ((|pin_fault) || (|pair_short)));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(pin_fault) && $stable(pair_short) && $stable(fail)));

    // R7
    excl_clean_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pin_fault & excl_q) == '0));

    // R7
    excl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(pad_dir & excl_q) && $stable(pad_out & excl_q)));

    // R8
    digital_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !mode_q) |-> ($stable(pad_dir) && $stable(pad_out)));

    // R8
    digital_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> ((pin_fault == '0) && (pair_short == '0)));
endmodule

bind gpio_lbist gpio_lbist_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .fail(fail), .pin_fault(pin_fault), .pair_short(pair_short),
    .pad_dir(pad_dir), .pad_out(pad_out), .mode_q(mode_q), .excl_q(excl_q)
);

// File: tb/sim_gpio_lbist.sv
`timescale 1ns/1ps
module sim_gpio_lbist;
    localparam int N  = 6;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [SW-1:0] settle = '0;
    logic [N-1:0]  excl = '0, func_dir = '0, func_out = '0;
    logic [N-1:0]  pad_dir, pad_out, pad_in, pin_fault;
    logic [N-2:0]  pair_short;
    logic          busy, done, fail;

    logic [N-1:0]  inj_s0 = '0, inj_s1 = '0;
    logic [N-2:0]  inj_sh = '0;

    always #2.5 clk = ~clk;

    gpio_lbist #(.N_PINS(N), .SETTLE_W(SW)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .settle_cycles(settle), .excl_mask(excl),
        .func_dir(func_dir), .func_out(func_out),
        .pad_dir(pad_dir), .pad_out(pad_out), .pad_in(pad_in),
        .busy(busy), .done(done), .fail(fail),
        .pin_fault(pin_fault), .pair_short(pair_short)
    );

    // wired-AND pads with pull-ups, injectable stuck levels and shorts
    function automatic logic [N-1:0] pad_model(input logic [N-1:0] d, input logic [N-1:0] o,
                                               input logic [N-1:0] s0, input logic [N-1:0] s1,
                                               input logic [N-2:0] sh);
        logic [N-1:0] v;
        logic a;
        for (int i = 0; i < N; i++) v[i] = d[i] ? o[i] : 1'b1;
        for (int k = 0; k < N; k++)
            for (int p = 0; p < N-1; p++)
                if (sh[p]) begin
                    a = v[p] & v[p+1];
                    v[p] = a;
                    v[p+1] = a;
                end
        return (v & ~s0) | s1;
    endfunction

    always_comb pad_in = pad_model(pad_dir, pad_out, inj_s0, inj_s1, inj_sh);

    typedef struct {
        logic [N-1:0] fault;
        logic [N-2:0] shrt;
        logic         fl;
        int           cyc;
        logic [N-1:0] hold;
        logic [N-1:0] sdir;
        logic [N-1:0] sout;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0, runs_done = 0, runs_sent = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor
    int           m_cyc = 0;
    logic [N-1:0] m_herr = '0, m_pdir = '0, m_pout = '0;
    logic         m_donep = 1'b0;
    exp_t         m_e;

    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                m_cyc = 0;
                m_herr = '0;
                m_donep = done;
            end else begin
                if (busy && q.size() > 0) begin
                    m_cyc++;
                    m_herr |= q[0].hold & ((pad_dir ^ q[0].sdir) | (pad_out ^ q[0].sout));
                end
                if (done && !m_donep) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R2 unexpected completion", 1, 0);
                    end else begin
                        m_e = q.pop_front();
                        chk(pin_fault == m_e.fault, "R4 pin_fault", pin_fault, m_e.fault);
                        chk(pair_short == m_e.shrt, "R5 pair_short", pair_short, m_e.shrt);
                        chk(fail == m_e.fl, "R10 fail", fail, m_e.fl);
                        chk(m_cyc == m_e.cyc, "R3 busy cycles", m_cyc, m_e.cyc);
                        chk(m_herr == '0, (m_e.hold == '1) ? "R8 pins held" : "R7 excluded held",
                            m_herr, 0);
                        chk(m_pdir == m_e.sdir && m_pout == m_e.sout, "R9 restore cycle",
                            {m_pdir, m_pout}, {m_e.sdir, m_e.sout});
                        chk(pad_dir == func_dir && pad_out == func_out, "R9 pass-through after run",
                            {pad_dir, pad_out}, {func_dir, func_out});
                    end
                    m_cyc = 0;
                    m_herr = '0;
                    runs_done++;
                end
                m_donep = done;
                m_pdir  = pad_dir;
                m_pout  = pad_out;
            end
        end
    end

    // driver: push expected item, start run, wait for completion
    task automatic run(input logic md, input logic [N-1:0] ex, input logic [SW-1:0] s,
                       input logic [N-1:0] s0, input logic [N-1:0] s1, input logic [N-2:0] sh,
                       input bit disturb);
        exp_t e;
        e.fault = md ? (~ex & (s0 | s1)) : '0;
        for (int p = 0; p < N-1; p++)
            e.shrt[p] = md & sh[p] & ~ex[p] & ~ex[p+1] & ~e.fault[p] & ~e.fault[p+1];
        e.fl   = (|e.fault) || (|e.shrt);
        e.cyc  = (2 + 2*(N-1)) * (int'(s) + 1) + 1;
        e.hold = md ? ex : '1;
        e.sdir = func_dir;
        e.sout = func_out;
        @(negedge clk);
        mode = md; excl = ex; settle = s;
        inj_s0 = s0; inj_s1 = s1; inj_sh = sh;
        start = 1'b1;
        q.push_back(e);
        runs_sent++;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        chk(done == 1'b0 && fail == 1'b0 && pin_fault == '0 && pair_short == '0,
            "R10 cleared by start", {done, fail}, 0);
        if (disturb) begin
            repeat (3) @(negedge clk);
            func_dir = ~func_dir;
            func_out = func_out ^ 6'b011010;
            start = 1'b1;          // R2: ignored while busy
            @(negedge clk);
            start = 1'b0;
            // change the latched inputs too; must not matter
            mode = ~md; excl = ~ex; settle = ~s;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && fail == 0, "R1 reset flags", {busy, done, fail}, 0);
        chk(pin_fault == '0 && pair_short == '0, "R1 reset results", {pin_fault, pair_short}, 0);
        func_dir = 6'b101011;
        func_out = 6'b110001;
        @(negedge clk);
        chk(pad_dir == func_dir && pad_out == func_out, "R1 idle pass-through",
            {pad_dir, pad_out}, {func_dir, func_out});

        // clean pad run
        run(1'b1, '0, 3'd2, '0, '0, '0, 1'b0);
        // stuck-at-0 on pin 2, stuck-at-1 on pin 4 (R4, R6 masking)
        run(1'b1, '0, 3'd0, 6'b000100, 6'b010000, '0, 1'b0);
        repeat (5) @(negedge clk);
        chk(fail == 1'b1 && done == 1'b1, "R10 fail sticky", {fail, done}, 2'b11);
        chk(pin_fault == 6'b010100, "R10 results held", pin_fault, 6'b010100);
        // shorts on pairs 1 and 3 (R5)
        run(1'b1, '0, 3'd3, '0, '0, 5'b01010, 1'b0);
        // shorts on the bank edges
        run(1'b1, '0, 3'd1, '0, '0, 5'b10001, 1'b0);
        // exclusion at both edges (R6, R7)
        func_dir = 6'b000001;
        func_out = 6'b000001;
        run(1'b1, 6'b100001, 3'd1, 6'b100000, '0, 5'b10001, 1'b0);
        // digital loop hides pad faults (R8)
        func_dir = 6'b110100;
        func_out = 6'b010110;
        run(1'b0, '0, 3'd2, 6'b000010, 6'b001000, 5'b00100, 1'b0);
        // mid-run disturbance: func change, ignored start (R2, R9), long settle
        run(1'b1, '0, 3'd7, '0, '0, 5'b00100, 1'b1);

        repeat (3) @(negedge clk);
        chk(runs_done == runs_sent && q.size() == 0, "R2 one completion per accepted start",
            runs_done, runs_sent);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule